// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single shared storage cell that works as a counting semaphore between requesters, such as hardware threads. Each request names an access view, a direction and a requester number. A take (P) is a read through one of the two semaphore views, and a give (V) is a write through either of them. The bypass view reads the count without changing it. The control view reads and writes three tag bits. The empty/full views belong to queue-type cells and do nothing on this one.

A blocking take that finds the count at zero does not complete. Instead, the requester's bit is set in a parked-requester mask and the response carries a block flag. The surrounding logic then halts that requester. The next give sends the whole mask out on a one-cycle wake pulse, which releases every parked requester so that each can retry, and the mask is cleared.

The controller has two states. ST_IDLE accepts a request when `req_valid` is high; this is transition T_ACCEPT, and it leads to ST_RESP. ST_RESP presents the response for exactly one cycle and returns to ST_IDLE by transition T_DONE. While no request arrives, ST_IDLE stays in ST_IDLE (T_WAIT).

Top module: `sem_cell`

## Requirements
- R1: After reset the count, the tag bits T/E/F and the parked mask are all zero, `req_ready` is 1, and `rsp_valid` and `wake_valid` are 0.
- R2: A request accepted in ST_IDLE gives `rsp_valid` high for exactly the next cycle. `req_ready` is low during that cycle.
- R3: A take (read on view 4 = blocking or view 5 = non-blocking) with a nonzero count returns the count as it was before the take, and decrements the count by one.
- R4: A non-blocking take (view 5) on a zero count returns 0 with `rsp_block` = 0 and changes nothing.
- R5: A blocking take (view 4) on a zero count returns 0 with `rsp_block` = 1, sets the requester's bit in the parked mask, and leaves the count at zero.
- R6: A give (write on view 4 or 5; both behave the same and the data is ignored) increments the count unless it is already at all ones of CNT_W bits (0xFFFF by default), where it stays.
- R7: A give while the parked mask is nonzero raises `wake_valid` in its response cycle, with `wake_mask` equal to the mask, and clears the mask. A give with an empty mask raises no wake.
- R8: A bypass read (view 0) returns the count unchanged. A bypass write has no effect.
- R9: Reads on the empty/full views (2 and 3) return 0. Writes on them have no effect.
- R10: A control write (view 1) loads T from data bit 16, F from bit 1 and E from bit 0. A control read returns those bits at the same positions, with every other bit 0; the queue flag at bit 17 reads 0.
- R11: Reads on the unused views 6 and 7 return all ones. Writes on them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | High in ST_IDLE; a request is accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | Access view code |
| req_id | input | ID_W | Requester number |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_data | output | DATA_W | Read data (0 for writes) |
| rsp_block | output | 1 | Blocking take parked the requester |
| wake_valid | output | 1 | Wake pulse |
| wake_mask | output | REQ_N | Requesters to wake |

## Verification
On every cycle, the assertions check the following:
- the one-cycle response handshake;
- that the count never moves by more than one step and never wraps at either end;
- that a wake pulse always carries a nonempty mask and coincides with an emptied mask;
- that a blocked response carries no data.

Only the bench scenarios can show the values returned by each view, the order of takes and gives around zero, saturation at the top of the count, the exact mask carried by a wake, and that writes on the ignored views leave the count and tags untouched.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

    localparam logic [2:0] VIEW_RAW     = 3'd0;
    localparam logic [2:0] VIEW_TAG     = 3'd1;
    localparam logic [2:0] VIEW_EF_WAIT = 3'd2;
    localparam logic [2:0] VIEW_EF_POLL = 3'd3;
    localparam logic [2:0] VIEW_PV_WAIT = 3'd4;
    localparam logic [2:0] VIEW_PV_POLL = 3'd5;

    localparam int TAG_E_BIT    = 0;
    localparam int TAG_F_BIT    = 1;
    localparam int TAG_T_BIT    = 16;
    localparam int TAG_QUEUE_BIT = 17;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TAKE,
        OP_GIVE,
        OP_PEEK,
        OP_TAG_RD,
        OP_TAG_WR,
        OP_ZERO,
        OP_ONES
    } op_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } st_e;

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
    import sem_cell_pkg::*;
(
    input  logic [2:0] view,
    input  logic       is_write,
    output op_e        op,
    output logic       wait_flag
);

    always_comb begin
        op        = OP_NONE;
        wait_flag = 1'b0;
        unique case (view)
            VIEW_RAW:     op = is_write ? OP_NONE   : OP_PEEK;
            VIEW_TAG:     op = is_write ? OP_TAG_WR : OP_TAG_RD;
            VIEW_EF_WAIT,
            VIEW_EF_POLL: op = is_write ? OP_NONE   : OP_ZERO;
            VIEW_PV_WAIT,
            VIEW_PV_POLL: begin
                op        = is_write ? OP_GIVE : OP_TAKE;
                wait_flag = (view == VIEW_PV_WAIT);
            end
            default:      op = is_write ? OP_NONE   : OP_ONES;
        endcase
    end

endmodule

// File: rtl/sem_counter.sv
module sem_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_en,
    input  logic             inc_en,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign is_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (dec_en && !is_zero) begin
            cnt <= cnt - 1'b1;
        end else if (inc_en && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1)); // R3
    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt != '0)); // R6
    AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> (cnt != CNT_MAX)); // R4

endmodule

// File: rtl/sem_park_mask.sv
module sem_park_mask #(
    parameter int REQ_N = 8,
    parameter int ID_W  = $clog2(REQ_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park_en,
    input  logic [ID_W-1:0]  park_id,
    input  logic             flush_en,
    output logic [REQ_N-1:0] mask
);

    for (genvar g = 0; g < REQ_N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[g] <= 1'b0;
            end else if (flush_en) begin
                mask[g] <= 1'b0;
            end else if (park_en && (park_id == ID_W'(g))) begin
                mask[g] <= 1'b1;
            end
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (mask == '0)); // R7
    AST_PARK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (park_en && !flush_en) |=> (mask != '0)); // R5

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int REQ_N  = 8,
    parameter int ID_W   = $clog2(REQ_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [2:0]        req_view,
    input  logic [ID_W-1:0]   req_id,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_block,
    output logic              wake_valid,
    output logic [REQ_N-1:0]  wake_mask
);

    st_e  state, st_nxt;
    op_e  op;
    logic wait_flag;
    logic accept;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_zero;
    logic [REQ_N-1:0]  park;
    logic              park_en, flush_en;
    logic              tag_t, tag_e, tag_f;
    logic [DATA_W-1:0] tag_word, rsp_word;
    logic [DATA_W-1:0] rsp_data_q;
    logic              rsp_block_q, wake_q;
    logic [REQ_N-1:0]  wake_mask_q;
    logic              wdata_unused;

    assign wdata_unused = ^req_wdata;

    sem_view_decode u_dec (
        .view      (req_view),
        .is_write  (req_write),
        .op        (op),
        .wait_flag (wait_flag)
    );

    assign accept   = req_valid && (state == ST_IDLE);
    assign park_en  = accept && (op == OP_TAKE) && wait_flag && cnt_zero;
    assign flush_en = accept && (op == OP_GIVE) && (park != '0);

    sem_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_en  (accept && (op == OP_TAKE)),
        .inc_en  (accept && (op == OP_GIVE)),
        .cnt     (cnt),
        .is_zero (cnt_zero)
    );

    sem_park_mask #(.REQ_N(REQ_N), .ID_W(ID_W)) u_park (
        .clk      (clk),
        .rst_n    (rst_n),
        .park_en  (park_en),
        .park_id  (req_id),
        .flush_en (flush_en),
        .mask     (park)
    );

    // Tag bits written through the control view
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_t <= 1'b0;
            tag_e <= 1'b0;
            tag_f <= 1'b0;
        end else if (accept && (op == OP_TAG_WR)) begin
            tag_t <= req_wdata[TAG_T_BIT];
            tag_e <= req_wdata[TAG_E_BIT];
            tag_f <= req_wdata[TAG_F_BIT];
        end
    end

    always_comb begin
        tag_word = '0;
        tag_word[TAG_T_BIT]     = tag_t;
        tag_word[TAG_F_BIT]     = tag_f;
        tag_word[TAG_E_BIT]     = tag_e;
        tag_word[TAG_QUEUE_BIT] = 1'b0;
    end

    always_comb begin
        unique case (op)
            OP_TAKE, OP_PEEK: rsp_word = DATA_W'(cnt);
            OP_TAG_RD:        rsp_word = tag_word;
            OP_ONES:          rsp_word = '1;
            default:          rsp_word = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nxt;
    end

    // Transitions: T_WAIT, T_ACCEPT, T_DONE
    always_comb begin
        unique case (state)
            ST_IDLE: st_nxt = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data_q  <= '0;
            rsp_block_q <= 1'b0;
            wake_q      <= 1'b0;
            wake_mask_q <= '0;
        end else if (accept) begin
            rsp_data_q  <= rsp_word;
            rsp_block_q <= park_en;
            wake_q      <= flush_en;
            wake_mask_q <= flush_en ? park : '0;
        end else begin
            rsp_block_q <= 1'b0;
            wake_q      <= 1'b0;
            wake_mask_q <= '0;
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign rsp_valid  = (state == ST_RESP);
    assign rsp_data   = rsp_data_q;
    assign rsp_block  = rsp_block_q;
    assign wake_valid = wake_q;
    assign wake_mask  = wake_mask_q;

    AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready)); // R2
    AST_WAKE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (wake_mask != '0 && rsp_valid)); // R7
    AST_WAKE_MASK_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (park == '0)); // R7
    AST_BLOCK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_block |-> (rsp_data == '0 && cnt == '0)); // R5

endmodule

// File: tb/sem_cell_tb_top.sv
`timescale 1ns/1ps
module sem_cell_tb_top;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 32;
    localparam int REQ_N  = 8;
    localparam int ID_W   = 3;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [2:0]        req_view = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_block;
    logic              wake_valid;
    logic [REQ_N-1:0]  wake_mask;

    always #2 clk = ~clk;

    sem_cell #(.CNT_W(CNT_W), .DATA_W(DATA_W), .REQ_N(REQ_N), .ID_W(ID_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_block(rsp_block),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              blk;
        logic              wk;
        logic [REQ_N-1:0]  wm;
        string             rq;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int               m_cnt = 0;
    logic [REQ_N-1:0] m_park = '0;
    logic             m_t = 0, m_e = 0, m_f = 0;

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Driver: computes the expected response from the requirements and issues the request
    task automatic do_op(input bit wr, input logic [2:0] view, input int id,
                         input logic [DATA_W-1:0] wd, input string rq);
        exp_t e;
        e.data = '0; e.blk = 0; e.wk = 0; e.wm = '0; e.rq = rq;
        if (view == 3'd4 || view == 3'd5) begin
            if (wr) begin
                if (m_park != '0) begin e.wk = 1; e.wm = m_park; m_park = '0; end
                if (m_cnt < CMAX) m_cnt++;
            end else begin
                e.data = DATA_W'(m_cnt);
                if (m_cnt > 0) m_cnt--;
                else if (view == 3'd4) begin e.blk = 1; m_park[id] = 1'b1; end
            end
        end else if (view == 3'd0) begin
            if (!wr) e.data = DATA_W'(m_cnt);
        end else if (view == 3'd1) begin
            if (wr) begin m_t = wd[16]; m_f = wd[1]; m_e = wd[0]; end
            else begin e.data[16] = m_t; e.data[1] = m_f; e.data[0] = m_e; end
        end else if (view == 3'd2 || view == 3'd3) begin
            e.data = '0;
        end else begin
            if (!wr) e.data = '1;
        end
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_view = view;
        req_id = ID_W'(id); req_wdata = wd;
        check(req_ready == 1'b1, "R2 ready before accept", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready low in response cycle", 64'(req_ready), 64'd0);
    endtask

    // Monitor: pops and compares
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected response", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rsp_data == e.data, {e.rq, " data"}, 64'(rsp_data), 64'(e.data));
                    check(rsp_block == e.blk, {e.rq, " block"}, 64'(rsp_block), 64'(e.blk));
                    check(wake_valid == e.wk && wake_mask == e.wm, {e.rq, " wake"},
                          {wake_valid, 55'd0, wake_mask}, {e.wk, 55'd0, e.wm});
                end
            end else if (wake_valid) begin
                check(1'b0, "R7 wake outside response", 64'd1, 64'd0);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1 && rsp_valid == 0 && wake_valid == 0, "R1 outputs in reset",
              {61'd0, req_ready, rsp_valid, wake_valid}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1 && rsp_valid == 0 && wake_valid == 0, "R1 outputs after reset",
              {61'd0, req_ready, rsp_valid, wake_valid}, 64'd4);

        do_op(0, 3'd0, 0, 0, "R1 count zero");
        do_op(0, 3'd1, 0, 0, "R1 tags zero");
        do_op(0, 3'd5, 1, 0, "R4 try take on zero");
        do_op(0, 3'd0, 0, 0, "R4 count still zero");
        do_op(1, 3'd4, 0, 32'hDEAD_BEEF, "R6 give blocking view");
        do_op(1, 3'd5, 0, 32'h0, "R6 give try view");
        do_op(1, 3'd5, 0, 32'h1234, "R6 give data ignored");
        do_op(0, 3'd0, 0, 0, "R8 bypass read three");
        do_op(1, 3'd0, 0, 32'd99, "R8 bypass write");
        do_op(0, 3'd0, 0, 0, "R8 bypass write ignored");
        do_op(0, 3'd4, 0, 0, "R3 blocking take nonzero");
        do_op(0, 3'd5, 0, 0, "R3 try take nonzero");
        do_op(0, 3'd4, 3, 0, "R3 take last");
        do_op(0, 3'd4, 2, 0, "R5 park requester 2");
        do_op(0, 3'd4, 5, 0, "R5 park requester 5");
        do_op(0, 3'd0, 0, 0, "R5 count stays zero");
        do_op(1, 3'd4, 0, 0, "R7 give wakes parked");
        do_op(1, 3'd5, 0, 0, "R7 give no wake");
        do_op(0, 3'd2, 0, 0, "R9 ef wait read");
        do_op(0, 3'd3, 0, 0, "R9 ef poll read");
        do_op(1, 3'd2, 0, 32'h7, "R9 ef wait write");
        do_op(1, 3'd3, 0, 32'h7, "R9 ef poll write");
        do_op(0, 3'd0, 0, 0, "R9 count unchanged");
        do_op(1, 3'd1, 0, 32'h0001_0003, "R10 tag write");
        do_op(0, 3'd1, 0, 0, "R10 tag read back");
        do_op(1, 3'd1, 0, 32'hFFFF_FFFF, "R10 tag write all ones");
        do_op(0, 3'd1, 0, 0, "R10 other bits zero");
        do_op(1, 3'd1, 0, 32'h0000_0002, "R10 tag write F only");
        do_op(0, 3'd1, 0, 0, "R10 F only read");
        do_op(0, 3'd6, 0, 0, "R11 view 6 read");
        do_op(0, 3'd7, 0, 0, "R11 view 7 read");
        do_op(1, 3'd6, 0, 32'h1, "R11 view 6 write");
        do_op(1, 3'd7, 0, 32'h1, "R11 view 7 write");
        do_op(0, 3'd0, 0, 0, "R11 count unchanged");
        do_op(0, 3'd1, 0, 0, "R11 tags unchanged");
        while (m_cnt < CMAX) do_op(1, 3'd5, 0, 0, "R6 fill");
        for (int k = 0; k < 3; k++) do_op(1, 3'd4, 0, 0, "R6 give at top");
        do_op(0, 3'd0, 0, 0, "R6 saturated count");
        do_op(0, 3'd5, 4, 0, "R3 take from top");
        do_op(0, 3'd0, 0, 0, "R3 one below top");
        @(negedge clk);
        check(sb_q.size() == 0, "R2 all responses seen", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule